// File: doc/BRIEF.md
# Serial Slave with Buffer-Ready Handshake

This block is the receiving end of a four-wire serial link whose clock comes from an outside master. Words run from 2 to 16 bits, most significant bit first, and any of the four clock polarity and phase settings can be chosen. The slave shifts only while its select line is low. It drives its serial data output only in that window and releases it otherwise. The serial clock, select and data input are brought into the system clock domain through a synchronizer chain. The edges of the serial clock are found there.

The local side writes one transmit word into a hold register and reads each received word from a receive register. A valid flag and an overrun flag go with the received word. The transmit word is taken from the hold register at the first output-shift edge of a word, and that empties the register. A handshake output tells the master that the next transmit word is staged. In the five-wire arrangement this output is also qualified by the select line, so several slaves can share one handshake wire. The output can be driven push-pull, or open-drain, which is modelled as an output-enable.

Top module: `spi_ready_slave`

## Requirements
- R1: After reset, tx_full, rx_valid, rx_overrun, miso_oe and rdy_o are all 0.
- R2: While cs_n is high, miso_oe is 0, serial clock edges are ignored, no word is received and the hold register is not consumed.
- R3: With word length N = cfg_bits_m1 + 1 (cfg_bits_m1 from 1 to 15), the slave sends the hold register's low N bits MSB first in every cfg_cpol/cfg_cpha setting. Data is sampled on the leading clock edge when cfg_cpha = 0 and on the trailing edge when cfg_cpha = 1. The output changes only after trailing edges.
- R4: After the N-th sampling edge, the word sampled from mosi (MSB first) is placed in rx_rdata[N-1:0] with the upper bits 0, and rx_valid is set. A pulse on rx_re clears rx_valid.
- R5: If the hold register is empty when a word starts, the slave sends all zeros.
- R6: The hold register is consumed at the first trailing edge of each word, and that clears tx_full. A tx_we that lands in the same cycle writes the new word and keeps tx_full at 1, while the consumed (sent) word is the old one. A write that lands one cycle earlier replaces the word's bits after the first.
- R7: With cfg_rdy_en = 1, cfg_five_pin = 0 and cfg_open_drain = 0, rdy_o follows tx_full with one cycle of delay and rdy_oe is 1. With cfg_rdy_en = 0, rdy_o and rdy_oe are both 0.
- R8: With cfg_five_pin = 1, the ready condition also requires cs_n to be low. A staged word with cs_n high gives rdy_o = 0.
- R9: With cfg_open_drain = 1, rdy_o is 0 and rdy_oe is 1 exactly when the ready condition is false, which pulls the line low. When the condition is true the line is released.
- R10: If cs_n rises before N bits have been sampled, the partial word is discarded (rx_valid stays 0) and the bit counters restart, so the next word is received whole.
- R11: If a word completes while rx_valid is 1 and rx_re is 0, rx_overrun is set and rx_rdata takes the new word. rx_re clears both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_cpol | input | 1 | Idle level of the serial clock |
| cfg_cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| cfg_bits_m1 | input | 4 | Word length minus one (1..15) |
| cfg_five_pin | input | 1 | Qualify ready with the select line |
| cfg_rdy_en | input | 1 | Enable the ready output |
| cfg_open_drain | input | 1 | Ready output in open-drain form |
| sclk | input | 1 | Serial clock from the master |
| cs_n | input | 1 | Active-low select |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Drive enable for miso |
| rdy_o | output | 1 | Ready drive value |
| rdy_oe | output | 1 | Ready drive enable |
| tx_we | input | 1 | Write the hold register |
| tx_wdata | input | 16 | Word to send |
| tx_full | output | 1 | Hold register holds a word |
| rx_re | input | 1 | Acknowledge the received word |
| rx_rdata | output | 16 | Last received word |
| rx_valid | output | 1 | Unread received word present |
| rx_overrun | output | 1 | A received word was overwritten unread |

## Verification
A local write to the hold register and the consumption of that register by the first trailing edge of a word can fall in the same system-clock cycle. The bench provokes this by placing a one-cycle tx_we one, two and three cycles after it toggles the first trailing edge of the serial clock, which brackets the cycle the synchronizer delay gives, in both phase settings. It judges the word seen on miso, tx_full afterwards, and the word sent by a following transfer against a model that chooses old, mixed or new data by that offset.

// File: rtl/spi_slv_pkg.sv
// Shared types for the serial slave.
// Assumes: nothing beyond standard SystemVerilog.
package spi_slv_pkg;
    // Serial-side events, already in the system clock domain.
    typedef struct packed {
        logic cs_act;   // select line low (synchronized)
        logic lead;     // leading serial clock edge while selected
        logic trail;    // trailing serial clock edge while selected
        logic mosi;     // synchronized data input, aligned with the edges
    } spi_evt_t;
endpackage

// File: rtl/spi_slv_sync.sv
// Synchronizes sclk, cs_n and mosi into clk and finds serial clock edges.
// Assumes: the serial clock is slower than clk/4 so every level is seen
// for at least two clk cycles; all three inputs pass equal-depth chains.
module spi_slv_sync
    import spi_slv_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cpol,
    input  logic     sclk,
    input  logic     cs_n,
    input  logic     mosi,
    output spi_evt_t evt
);
    logic [2:0] pins_raw;
    logic [2:0] pins_s;
    logic       lvl;
    logic       lvl_d;

    assign pins_raw = {sclk, cs_n, mosi};

    for (genvar s = 0; s < STAGES; s++) begin : g_stg
        logic [2:0] q;
        if (s == 0) begin : g_first
            // Capture the raw pins.
            always_ff @(posedge clk) begin
                if (!rst_n) q <= 3'b010;
                else        q <= pins_raw;
            end
        end else begin : g_next
            // Pass the previous stage on.
            always_ff @(posedge clk) begin
                if (!rst_n) q <= 3'b010;
                else        q <= g_stg[s-1].q;
            end
        end
    end

    assign pins_s = g_stg[STAGES-1].q;
    assign lvl    = pins_s[2] ^ cpol;

    // Remember the normalized clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_d <= 1'b0;
        else        lvl_d <= lvl;
    end

    // Build the event word; edges count only while selected.
    always_comb begin
        evt.cs_act = ~pins_s[1];
        evt.lead   = evt.cs_act & lvl & ~lvl_d;
        evt.trail  = evt.cs_act & ~lvl & lvl_d;
        evt.mosi   = pins_s[0];
    end
endmodule

// File: rtl/spi_slv_tx.sv
// Transmit side: hold register, output shifter and drive-edge counter.
// Assumes: word length is stable while selected; the hold register is
// consumed at the first trailing edge of a word, and a local write in
// that same cycle wins the register.
module spi_slv_tx #(
    parameter int W  = 16,
    parameter int BW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_act,
    input  logic          trail,
    input  logic [BW-1:0] bits_m1,
    input  logic          tx_we,
    input  logic [W-1:0]  tx_wdata,
    output logic          tx_full,
    output logic          miso,
    output logic          miso_oe
);
    logic [W-1:0]  hold_q;
    logic [W-1:0]  sh_q;
    logic [BW-1:0] cnt_q;
    logic          first;
    logic          take;
    logic          out_bit;

    assign first = (cnt_q == '0);
    assign take  = trail & first;

    // Count trailing edges within the current word.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_act) cnt_q <= '0;
        else if (trail)        cnt_q <= (cnt_q == bits_m1) ? '0 : cnt_q + 1'b1;
    end

    // Load from the hold register on the first edge, then shift left.
    always_ff @(posedge clk) begin
        if (!rst_n)     sh_q <= '0;
        else if (take)  sh_q <= (tx_full ? hold_q : '0) << 1;
        else if (trail) sh_q <= sh_q << 1;
    end

    // Hold register: local write sets it, first-edge take empties it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q  <= '0;
            tx_full <= 1'b0;
        end else if (tx_we) begin
            hold_q  <= tx_wdata;
            tx_full <= 1'b1;
        end else if (take) begin
            tx_full <= 1'b0;
        end
    end

    // First bit comes straight from the hold register, later bits from the shifter.
    assign out_bit = first ? (tx_full & hold_q[bits_m1]) : sh_q[bits_m1];
    assign miso    = cs_act & out_bit;
    assign miso_oe = cs_act;
endmodule

// File: rtl/spi_slv_rx.sv
// Receive side: input shifter, sample-edge counter, receive register and flags.
// Assumes: a word completes on its N-th sampling edge; deselecting early
// clears the partial word.
module spi_slv_rx #(
    parameter int W  = 16,
    parameter int BW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_act,
    input  logic          lead,
    input  logic          trail,
    input  logic          sdi,
    input  logic          cpha,
    input  logic [BW-1:0] bits_m1,
    input  logic          rx_re,
    output logic [W-1:0]  rx_rdata,
    output logic          rx_valid,
    output logic          rx_overrun
);
    logic [W-2:0]  sh_q;
    logic [BW-1:0] cnt_q;
    logic          samp;
    logic          last;
    logic          done;

    assign samp = cpha ? trail : lead;
    assign last = (cnt_q == bits_m1);
    assign done = samp & last;

    // Shift in sampled bits; restart at word end or on deselect.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_act) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (samp) begin
            if (last) begin
                sh_q  <= '0;
                cnt_q <= '0;
            end else begin
                sh_q  <= {sh_q[W-3:0], sdi};
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Receive register and its valid/overrun flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_rdata   <= '0;
            rx_valid   <= 1'b0;
            rx_overrun <= 1'b0;
        end else if (done) begin
            rx_rdata   <= {sh_q, sdi};
            rx_valid   <= 1'b1;
            rx_overrun <= ~rx_re & (rx_valid | rx_overrun);
        end else if (rx_re) begin
            rx_valid   <= 1'b0;
            rx_overrun <= 1'b0;
        end
    end
endmodule

// File: rtl/spi_slv_ready.sv
// Ready handshake driver: push-pull or open-drain, optionally qualified by select.
// Assumes: the output is registered so it never glitches.
module spi_slv_ready (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic five_pin,
    input  logic open_drain,
    input  logic tx_full,
    input  logic cs_act,
    output logic rdy_o,
    output logic rdy_oe
);
    logic cond;

    assign cond = tx_full & (~five_pin | cs_act);

    // Register drive value and enable for the selected output form.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            rdy_o  <= 1'b0;
            rdy_oe <= 1'b0;
        end else if (open_drain) begin
            rdy_o  <= 1'b0;
            rdy_oe <= ~cond;
        end else begin
            rdy_o  <= cond;
            rdy_oe <= 1'b1;
        end
    end
endmodule

// File: rtl/spi_ready_slave.sv
// Top level of the serial slave with a buffer-ready handshake output.
// Assumes: the serial clock runs below clk/4; configuration is stable
// while cs_n is low; cfg_bits_m1 is at least 1.
module spi_ready_slave
    import spi_slv_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int SYNC_STAGES = 2,
    localparam int BW         = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic [BW-1:0]     cfg_bits_m1,
    input  logic              cfg_five_pin,
    input  logic              cfg_rdy_en,
    input  logic              cfg_open_drain,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              mosi,
    output logic              miso,
    output logic              miso_oe,
    output logic              rdy_o,
    output logic              rdy_oe,
    input  logic              tx_we,
    input  logic [WORD_W-1:0] tx_wdata,
    output logic              tx_full,
    input  logic              rx_re,
    output logic [WORD_W-1:0] rx_rdata,
    output logic              rx_valid,
    output logic              rx_overrun
);
    spi_evt_t evt;
    logic     cs_act;

    assign cs_act = evt.cs_act;

    spi_slv_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk (clk), .rst_n(rst_n), .cpol(cfg_cpol),
        .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .evt(evt)
    );

    spi_slv_tx #(.W(WORD_W), .BW(BW)) i_tx (
        .clk     (clk),      .rst_n   (rst_n),
        .cs_act  (evt.cs_act), .trail (evt.trail),
        .bits_m1 (cfg_bits_m1),
        .tx_we   (tx_we),    .tx_wdata(tx_wdata), .tx_full(tx_full),
        .miso    (miso),     .miso_oe (miso_oe)
    );

    spi_slv_rx #(.W(WORD_W), .BW(BW)) i_rx (
        .clk     (clk),      .rst_n (rst_n),
        .cs_act  (evt.cs_act), .lead(evt.lead), .trail(evt.trail),
        .sdi     (evt.mosi), .cpha  (cfg_cpha), .bits_m1(cfg_bits_m1),
        .rx_re   (rx_re),    .rx_rdata(rx_rdata),
        .rx_valid(rx_valid), .rx_overrun(rx_overrun)
    );

    spi_slv_ready i_rdy (
        .clk       (clk),          .rst_n   (rst_n),
        .en        (cfg_rdy_en),   .five_pin(cfg_five_pin),
        .open_drain(cfg_open_drain), .tx_full(tx_full),
        .cs_act    (evt.cs_act),
        .rdy_o     (rdy_o),        .rdy_oe  (rdy_oe)
    );
endmodule

// File: rtl/spi_ready_slave_chk.sv
// Property checker for spi_ready_slave, attached with bind below.
// Assumes: observes ports plus the synchronized select state.
module spi_ready_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_five_pin,
    input logic cfg_rdy_en,
    input logic cfg_open_drain,
    input logic cs_act,
    input logic tx_we,
    input logic tx_full,
    input logic rx_re,
    input logic rx_valid,
    input logic rx_overrun,
    input logic rdy_o,
    input logic rdy_oe
);
    // R7
    rdy_follows_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_o |-> ($past(tx_full) && $past(cfg_rdy_en)));

    // R8
    rdy_five_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_o && $past(cfg_five_pin)) |-> $past(cs_act));

    // R9
    rdy_od_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_open_drain) |-> !rdy_o);

    // R9
    rdy_od_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_oe && $past(cfg_open_drain)) |->
            !($past(tx_full) && ($past(!cfg_five_pin) || $past(cs_act))));

    // R2
    tx_take_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_full) |-> $past(cs_act));

    // R4
    rx_done_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_valid) |-> $past(cs_act));

    // R11
    rx_overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_overrun) |-> ($past(rx_valid) && !$past(rx_re)));

    // R6
    tx_write_sets_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_we |=> tx_full);
endmodule

bind spi_ready_slave spi_ready_slave_chk i_chk (
    .clk(clk), .rst_n(rst_n), .cfg_five_pin(cfg_five_pin),
    .cfg_rdy_en(cfg_rdy_en), .cfg_open_drain(cfg_open_drain),
    .cs_act(cs_act), .tx_we(tx_we), .tx_full(tx_full), .rx_re(rx_re),
    .rx_valid(rx_valid), .rx_overrun(rx_overrun),
    .rdy_o(rdy_o), .rdy_oe(rdy_oe)
);

// File: tb/test_spi_ready_slave.sv
module test_spi_ready_slave;
    localparam int H = 8;   // serial half period in clk cycles

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_cpol, cfg_cpha, cfg_five_pin, cfg_rdy_en, cfg_open_drain;
    logic [3:0]  cfg_bits_m1;
    logic        sclk, cs_n, mosi;
    logic        miso, miso_oe, rdy_o, rdy_oe;
    logic        tx_we, tx_full, rx_re, rx_valid, rx_overrun;
    logic [15:0] tx_wdata, rx_rdata;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    spi_ready_slave i_spi_ready_slave (
        .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .cfg_bits_m1(cfg_bits_m1), .cfg_five_pin(cfg_five_pin),
        .cfg_rdy_en(cfg_rdy_en), .cfg_open_drain(cfg_open_drain),
        .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso), .miso_oe(miso_oe),
        .rdy_o(rdy_o), .rdy_oe(rdy_oe), .tx_we(tx_we), .tx_wdata(tx_wdata),
        .tx_full(tx_full), .rx_re(rx_re), .rx_rdata(rx_rdata),
        .rx_valid(rx_valid), .rx_overrun(rx_overrun)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mask_n(input int n);
        return 16'((32'd1 << n) - 1);
    endfunction

    // Word a correct slave sends when a write lands at offset c after the first trailing edge.
    function automatic logic [15:0] mixed_word(input int n, input int c,
                                               input logic [15:0] old_w, input logic [15:0] new_w);
        logic [15:0] top;
        top = 16'(32'd1 << (n - 1));
        if (c < 2) return (old_w & top) | (new_w & (top - 16'd1));
        return old_w & mask_n(n);
    endfunction

    task automatic settle(input int k);
        repeat (k) @(negedge clk);
    endtask

    // Wait H cycles; optionally pulse tx_we at cycle k.
    task automatic wait_h(input bit hook, input int k, input logic [15:0] d);
        for (int c = 0; c < H; c++) begin
            if (hook && c == k) begin
                tx_we = 1'b1;
                tx_wdata = d;
            end else begin
                tx_we = 1'b0;
            end
            @(negedge clk);
        end
        tx_we = 1'b0;
    endtask

    task automatic write_tx(input logic [15:0] d);
        tx_we = 1'b1; tx_wdata = d;
        @(negedge clk);
        tx_we = 1'b0;
    endtask

    task automatic read_rx();
        rx_re = 1'b1;
        @(negedge clk);
        rx_re = 1'b0;
        @(negedge clk);
    endtask

    task automatic cs_low();
        sclk = cfg_cpol;
        settle(H);
        cs_n = 1'b0;
        settle(H);
    endtask

    task automatic cs_high();
        settle(H);
        cs_n = 1'b1;
        settle(H);
    endtask

    // Master side of one word of n bits; k < 0 disables the write hook.
    task automatic shift_word(input int n, input logic [15:0] mo, output logic [15:0] got,
                              input int k, input logic [15:0] d);
        bit pend = 0;
        got = '0;
        for (int i = n - 1; i >= 0; i--) begin
            if (!cfg_cpha) begin
                mosi = mo[i];
                wait_h(pend && k >= 0, k, d);
                pend = 0;
                sclk = ~cfg_cpol;
                got[i] = miso;
                wait_h(0, 0, '0);
                sclk = cfg_cpol;
                pend = (i == n - 1);
            end else begin
                sclk = ~cfg_cpol;
                mosi = mo[i];
                wait_h(0, 0, '0);
                got[i] = miso;
                sclk = cfg_cpol;
                wait_h((i == n - 1) && k >= 0, k, d);
            end
        end
        wait_h(pend && k >= 0, k, d);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        logic [15:0] got, got2, dtx, drx;
        int n;
        bit wr;
        void'($urandom(32'd1234));
        rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; mosi = 1'b0;
        cfg_cpol = 0; cfg_cpha = 0; cfg_bits_m1 = 4'd15;
        cfg_five_pin = 0; cfg_rdy_en = 1; cfg_open_drain = 0;
        tx_we = 0; tx_wdata = '0; rx_re = 0;
        settle(5);
        rst_n = 1'b1;
        settle(1);

        // R1 reset state
        chk("R1 tx_full", tx_full, 0);
        chk("R1 rx_valid", rx_valid, 0);
        chk("R1 rx_overrun", rx_overrun, 0);
        chk("R1 miso_oe", miso_oe, 0);
        chk("R1 rdy_o", rdy_o, 0);

        // R7 push-pull ready follows the hold register
        write_tx(16'hA5C3);
        settle(2);
        chk("R7 rdy_o staged", rdy_o, 1);
        chk("R7 rdy_oe", rdy_oe, 1);

        // R2 clocks with select high are ignored
        for (int i = 0; i < 10; i++) begin
            sclk = ~sclk;
            settle(H);
        end
        sclk = cfg_cpol;
        settle(H);
        chk("R2 tx_full kept", tx_full, 1);
        chk("R2 rx_valid", rx_valid, 0);
        chk("R2 miso_oe", miso_oe, 0);

        // R3/R4 directed 16-bit word, mode 0
        cs_low();
        chk("R2 miso_oe selected", miso_oe, 1);
        shift_word(16, 16'h3C5A, got, -1, '0);
        cs_high();
        chk("R3 miso word", got, 16'hA5C3);
        chk("R4 rx word", rx_rdata, 16'h3C5A);
        chk("R4 rx_valid", rx_valid, 1);
        chk("R6 tx_full after take", tx_full, 0);
        chk("R7 rdy_o empty", rdy_o, 0);
        read_rx();
        chk("R4 rx_valid cleared", rx_valid, 0);

        // R5 empty hold register sends zeros, mode 3, 8 bits
        cfg_cpol = 1; cfg_cpha = 1; cfg_bits_m1 = 4'd7;
        cs_low();
        shift_word(8, 8'hE7, got, -1, '0);
        cs_high();
        chk("R5 zeros sent", got, 0);
        chk("R4 rx 8-bit", rx_rdata, 16'h00E7);
        read_rx();

        // R8 five-pin qualification
        cfg_five_pin = 1;
        write_tx(16'h0096);
        settle(3);
        chk("R8 rdy_o deselected", rdy_o, 0);
        sclk = cfg_cpol;
        cs_n = 1'b0;
        settle(5);
        chk("R8 rdy_o selected", rdy_o, 1);
        cs_n = 1'b1;
        settle(5);
        chk("R8 rdy_o after deselect", rdy_o, 0);
        cfg_five_pin = 0;

        // R9 open-drain form
        cfg_open_drain = 1;
        settle(3);
        chk("R9 oe released when ready", rdy_oe, 0);
        chk("R9 rdy_o low", rdy_o, 0);
        cs_low();
        shift_word(8, 8'h11, got, -1, '0);
        cs_high();
        chk("R3 mode 3 word", got, 16'h0096);
        chk("R9 oe pulls low when empty", rdy_oe, 1);
        chk("R9 rdy_o stays low", rdy_o, 0);
        read_rx();
        cfg_open_drain = 0;

        // R7 disabled output
        cfg_rdy_en = 0;
        settle(3);
        chk("R7 disabled rdy_oe", rdy_oe, 0);
        chk("R7 disabled rdy_o", rdy_o, 0);
        cfg_rdy_en = 1;

        // R6 write against first-edge take, both phases, three offsets
        cfg_bits_m1 = 4'd11;
        for (int ph = 0; ph < 2; ph++) begin
            for (int c = 1; c <= 3; c++) begin
                cfg_cpha = ph[0]; cfg_cpol = ph[0] ^ c[0];
                write_tx(16'h0ABC);
                cs_low();
                shift_word(12, 12'h123, got, c, 16'h0531);
                cs_high();
                chk("R6 collision word", got, mixed_word(12, c, 16'h0ABC, 16'h0531));
                chk("R6 collision tx_full", tx_full, (c >= 2) ? 1 : 0);
                read_rx();
                cs_low();
                shift_word(12, 12'h321, got2, -1, '0);
                cs_high();
                chk("R6 following word", got2, (c >= 2) ? 16'h0531 : 16'h0000);
                read_rx();
            end
        end

        // R10 early deselect discards the partial word
        cfg_cpol = 0; cfg_cpha = 0; cfg_bits_m1 = 4'd15;
        write_tx(16'hFFFF);
        cs_low();
        shift_word(5, 16'h001F, got, -1, '0);
        cs_high();
        chk("R10 no rx_valid", rx_valid, 0);
        write_tx(16'h6D2B);
        cs_low();
        shift_word(16, 16'hB00F, got, -1, '0);
        cs_high();
        chk("R10 next word tx", got, 16'h6D2B);
        chk("R10 next word rx", rx_rdata, 16'hB00F);
        read_rx();

        // R11 overrun with two words in one select window
        cfg_bits_m1 = 4'd9;
        write_tx(16'h02AA);
        cs_low();
        shift_word(10, 16'h0155, got, -1, '0);
        write_tx(16'h0333);
        shift_word(10, 16'h03C1, got2, -1, '0);
        cs_high();
        chk("R11 overrun set", rx_overrun, 1);
        chk("R11 newest word kept", rx_rdata, 16'h03C1);
        chk("R3 second word", got2, 16'h0333);
        read_rx();
        chk("R11 overrun cleared", rx_overrun, 0);
        chk("R11 valid cleared", rx_valid, 0);

        // R3/R4/R5 random modes and lengths
        for (int it = 0; it < 24; it++) begin
            cfg_cpol = 1'($urandom); cfg_cpha = 1'($urandom);
            n = 2 + int'($urandom % 15);
            cfg_bits_m1 = 4'(n - 1);
            dtx = 16'($urandom); drx = 16'($urandom);
            wr = ($urandom % 4) != 0;
            if (wr) write_tx(dtx);
            cs_low();
            shift_word(n, drx, got, -1, '0);
            cs_high();
            chk(wr ? "R3 random tx" : "R5 random empty", got, wr ? (dtx & mask_n(n)) : 16'h0);
            chk("R4 random rx", rx_rdata, drx & mask_n(n));
            chk("R4 random valid", rx_valid, 1);
            chk("R6 random emptied", tx_full, 0);
            read_rx();
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule